// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes written by a host into an NRZ serial stream. Each frame has one low start bit, then 8 data bits (or 9 when the extended mode is selected), least significant bit first, then one high stop bit. The line rests high between frames. Bit timing comes from an external one-cycle `bit_tick` pulse, issued once per bit period by a baud generator. All line transitions happen on clock edges where `bit_tick` is high.

Two storage stages sit in front of the line. The first is a holding register that the host fills through a valid/ready port. The second is a shift register that drives the line. A word moves from the holding register into the shift register only at a bit tick, and only when the shifter is idle or has just finished a stop bit. This lets software queue one word while another is being shifted, and lets queued words go out back to back with no idle gap. The ninth bit comes from software and can carry a parity value or an address flag. Hardware computes no parity.

The shifter is a five-state machine:
- IDLE holds the line high. At a tick, with transmit enabled and a word waiting, it loads the shift register and moves to START.
- START drives the line low for one tick period, then moves to DATA.
- DATA drives the low bit of the shift register and shifts at every tick. After the last base data bit it moves to NINTH when the extended mode was latched at load, otherwise to STOP.
- NINTH drives the software bit for one period, then moves to STOP.
- STOP drives the line high for one period. At its closing tick it either reloads and returns straight to START (transmit enabled and a word waiting), or falls back to IDLE.

Top module: `async_tx_dbuf`

## Requirements
- R1: After reset the line is high, `buf_empty` is 1, `shift_empty` is 1 and `wr_ready` is 1.
- R2: A frame is one low start bit, then data bits LSB first, then one high stop bit. Each bit lasts exactly one `bit_tick` period and the line changes only at clock edges where `bit_tick` is high.
- R3: With `nine_bit_mode`=1 at the moment a word is loaded into the shifter, the frame carries 9 data bits and the ninth is the `wr_bit9` value written with the word. With `nine_bit_mode`=0 the frame carries exactly 8 data bits and `wr_bit9` is not sent.
- R4: `wr_ready` equals `buf_empty`. A word offered with `wr_valid` while `wr_ready` is 1 is taken at that clock edge, and `buf_empty` is 0 from the next cycle.
- R5: `buf_empty` returns to 1 as soon as the held word moves into the shifter, while that frame is still being sent (`shift_empty`=0), so a further word can be queued.
- R6: The shift register is reloaded only at the tick that ends a stop bit (or from idle). A queued word's start bit begins exactly at the end of the previous stop bit, so frame starts are 10 bit periods apart in 8-bit mode.
- R7: `shift_empty` is 1 only when no frame is in progress and the holding register is empty. In particular it is 0 while a word waits in the holding register.
- R8: While `tx_en` is 0 no new frame starts. A frame already in progress completes, after which the line idles high and any waiting word stays held (`buf_empty`=0) until `tx_en` returns to 1.
- R9: An idle, enabled transmitter begins a frame's start bit at the first tick after the word is written, so the start bit is observed within two tick periods of the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| tx_en | input | 1 | Transmit enable; low stops new frames from starting |
| nine_bit_mode | input | 1 | 1 selects 9 data bits, sampled when a word is loaded |
| wr_valid | input | 1 | Host offers a word |
| wr_ready | output | 1 | Holding register can take a word |
| wr_data | input | DATA_W | Data bits of the offered word |
| wr_bit9 | input | 1 | Software-supplied ninth bit (parity or address flag) |
| tx_line | output | 1 | Serial output, idle high |
| buf_empty | output | 1 | Holding register empty |
| shift_empty | output | 1 | No frame in progress and holding register empty |

## Verification
The in-line assertions watch, on every cycle, the per-cycle rules:
- the line only moves on tick edges;
- a stop bit holds until its tick;
- an accepted word fills the holding register;
- the buffer empties only at a tick;
- the enable gate keeps an idle shifter idle;
- an empty transmitter drives the line high.

Only the bench's scenarios can show the rest: that the decoded bit order and the 8- or 9-bit lengths match the written words, that queued words follow with no gap, and that a frame cut off by a dropping enable still completes while the next word waits.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_NINTH = 3'd3,
        ST_STOP  = 3'd4
    } tx_state_e;
endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit9,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_bit9
);
    logic accept;

    assign wr_ready = ~full;
    assign accept   = wr_valid & ~full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full      <= 1'b0;
            hold_data <= '0;
            hold_bit9 <= 1'b0;
        end else if (accept) begin
            full      <= 1'b1;
            hold_data <= wr_data;
            hold_bit9 <= wr_bit9;
        end else if (take) begin
            full      <= 1'b0;
        end
    end

    // R4
    accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> full);
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import async_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              nine_bit_mode,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_bit9,
    output logic              take,
    output logic              busy,
    output logic              tx_line
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              b9_q;
    logic              nine_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and load request
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (bit_tick && tx_en && hold_full) begin
                    take    = 1'b1;
                    state_d = ST_START;
                end
            end
            ST_START: begin
                if (bit_tick) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_tick && cnt_q == LAST_BIT)
                    state_d = nine_q ? ST_NINTH : ST_STOP;
            end
            ST_NINTH: begin
                if (bit_tick) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (bit_tick) begin
                    if (tx_en && hold_full) begin
                        take    = 1'b1;
                        state_d = ST_START;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            b9_q   <= 1'b0;
            nine_q <= 1'b0;
        end else if (take) begin
            sh_q   <= hold_data;
            cnt_q  <= '0;
            b9_q   <= hold_bit9;
            nine_q <= nine_bit_mode;
        end else if (state_q == ST_DATA && bit_tick) begin
            sh_q   <= sh_q >> 1;
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        tx_line = 1'b1;
        busy    = 1'b1;
        unique case (state_q)
            ST_IDLE:  begin tx_line = 1'b1; busy = 1'b0; end
            ST_START: tx_line = 1'b0;
            ST_DATA:  tx_line = sh_q[0];
            ST_NINTH: tx_line = b9_q;
            ST_STOP:  tx_line = 1'b1;
            default:  begin tx_line = 1'b1; busy = 1'b0; end
        endcase
    end

    // R2
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !bit_tick) |=> (state_q == ST_STOP && tx_line));

    // R8
    idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !tx_en) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/async_tx_dbuf.sv
module async_tx_dbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              nine_bit_mode,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit9,
    output logic              tx_line,
    output logic              buf_empty,
    output logic              shift_empty
);
    logic              full;
    logic [DATA_W-1:0] hold_data;
    logic              hold_bit9;
    logic              take;
    logic              busy;

    tx_hold_buf #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .wr_data   (wr_data),
        .wr_bit9   (wr_bit9),
        .take      (take),
        .full      (full),
        .hold_data (hold_data),
        .hold_bit9 (hold_bit9)
    );

    tx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_tick      (bit_tick),
        .tx_en         (tx_en),
        .nine_bit_mode (nine_bit_mode),
        .hold_full     (full),
        .hold_data     (hold_data),
        .hold_bit9     (hold_bit9),
        .take          (take),
        .busy          (busy),
        .tx_line       (tx_line)
    );

    assign buf_empty   = ~full;
    assign shift_empty = ~busy & ~full;

    // R7
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> tx_line);

    // R6
    reload_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty) |-> $past(bit_tick));

    // R2
    line_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_tick) |-> $stable(tx_line));
endmodule

// File: tb/async_tx_dbuf_tb.sv
module async_tx_dbuf_tb;
    localparam int DW       = 8;
    localparam int TICK_DIV = 4;
    localparam int WD_LIMIT = 150000;
    localparam int NVEC     = 6;
    // entry layout: {nine_bit_mode, bit9, data[7:0]}
    localparam logic [9:0] VEC [NVEC] = '{
        10'h0A5, 10'h001, 10'h080, 10'h3C3, 10'h25A, 10'h0F0
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic tx_en = 1'b1;
    logic nine_bit_mode = 1'b0;
    logic wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic wr_bit9 = 1'b0;
    logic wr_ready, tx_line, buf_empty, shift_empty;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int div = 0;
    int tick_n = 0;

    // frame decoder state
    int rx_st = 0;
    int rx_cnt = 0;
    int rx_start = 0;
    logic [8:0] rx_word = '0;
    int dec_cnt = 0;
    logic [8:0] dec_word [16];
    logic       dec_stop [16];
    int         dec_start [16];

    async_tx_dbuf #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
        .nine_bit_mode(nine_bit_mode), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_data(wr_data), .wr_bit9(wr_bit9), .tx_line(tx_line),
        .buf_empty(buf_empty), .shift_empty(shift_empty)
    );

    always #5 clk = ~clk;

    // decode on tick samples, then advance tick generator
    always @(negedge clk) begin
        cycles++;
        if (rst_n && bit_tick) begin
            tick_n++;
            case (rx_st)
                0: if (tx_line == 1'b0) begin
                    rx_st = 1; rx_cnt = 0; rx_word = '0; rx_start = tick_n;
                end
                1: begin
                    rx_word[rx_cnt] = tx_line;
                    rx_cnt++;
                    if (rx_cnt == DW + int'(nine_bit_mode)) rx_st = 2;
                end
                default: begin
                    if (dec_cnt < 16) begin
                        dec_word[dec_cnt]  = rx_word;
                        dec_stop[dec_cnt]  = tx_line;
                        dec_start[dec_cnt] = rx_start;
                    end
                    dec_cnt++;
                    rx_st = 0;
                end
            endcase
        end
        div = (div == TICK_DIV - 1) ? 0 : div + 1;
        bit_tick = (div == TICK_DIV - 1);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [DW-1:0] d, input logic b9);
        bit done = 0;
        while (!done) begin
            @(negedge clk);
            if (wr_ready) begin
                wr_valid = 1'b1; wr_data = d; wr_bit9 = b9;
                @(negedge clk);
                wr_valid = 1'b0;
                chk(buf_empty == 1'b0, "R4 full after accept", int'(buf_empty), 0);
                done = 1;
            end
        end
    endtask

    task automatic wait_frames(input int target);
        while (dec_cnt < target) @(negedge clk);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!shift_empty || rx_st != 0) @(negedge clk);
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (cycles > WD_LIMIT) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int base, wtick, len;
        logic [8:0] expw;
        wait_cycles(3);
        // R1 reset state
        chk(tx_line == 1'b1, "R1 line", int'(tx_line), 1);
        chk(buf_empty == 1'b1, "R1 buf_empty", int'(buf_empty), 1);
        chk(shift_empty == 1'b1, "R1 shift_empty", int'(shift_empty), 1);
        chk(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);
        rst_n = 1'b1;
        wait_cycles(2);

        // vector table: R2, R3, R9
        for (int v = 0; v < NVEC; v++) begin
            nine_bit_mode = VEC[v][9];
            wait_idle();
            base = dec_cnt;
            wtick = tick_n;
            write_word(VEC[v][7:0], VEC[v][8]);
            wait_frames(base + 1);
            len = DW + int'(VEC[v][9]);
            expw = VEC[v][9] ? {VEC[v][8], VEC[v][7:0]} : {1'b0, VEC[v][7:0]};
            chk(dec_word[base] == expw, "R2/R3 data bits", int'(dec_word[base]), int'(expw));
            chk(dec_stop[base] == 1'b1, "R2 stop bit", int'(dec_stop[base]), 1);
            chk(dec_start[base] <= wtick + 2, "R9 start latency", dec_start[base], wtick + 2);
            wait_idle();
            chk(tx_line == 1'b1, "R2 idle high", int'(tx_line), 1);
            if (len == 0) chk(0, "R3 length", len, DW);
        end

        // back-to-back: R5, R6, R7
        nine_bit_mode = 1'b0;
        wait_idle();
        base = dec_cnt;
        write_word(8'h3C, 1'b0);
        chk(shift_empty == 1'b0, "R7 holding full", int'(shift_empty), 0);
        while (!buf_empty) @(negedge clk);
        chk(shift_empty == 1'b0, "R5 frame in flight", int'(shift_empty), 0);
        write_word(8'hE1, 1'b0);
        wait_frames(base + 2);
        chk(dec_word[base] == 9'h03C, "R6 first word", int'(dec_word[base]), 'h3C);
        chk(dec_word[base+1] == 9'h0E1, "R6 second word", int'(dec_word[base+1]), 'hE1);
        chk(dec_start[base+1] - dec_start[base] == DW + 2, "R6 no gap",
            dec_start[base+1] - dec_start[base], DW + 2);

        // enable low while idle: R8
        wait_idle();
        tx_en = 1'b0;
        base = dec_cnt;
        write_word(8'h96, 1'b0);
        wait_cycles(TICK_DIV * 15);
        chk(dec_cnt == base, "R8 no frame while disabled", dec_cnt, base);
        chk(buf_empty == 1'b0, "R8 word held", int'(buf_empty), 0);
        chk(tx_line == 1'b1, "R8 line idle", int'(tx_line), 1);
        chk(shift_empty == 1'b0, "R7 pending word", int'(shift_empty), 0);
        tx_en = 1'b1;
        wait_frames(base + 1);
        chk(dec_word[base] == 9'h096, "R8 resumes", int'(dec_word[base]), 'h96);

        // enable drops mid-frame: R8
        wait_idle();
        base = dec_cnt;
        write_word(8'h5E, 1'b0);
        while (!buf_empty) @(negedge clk);
        write_word(8'hA7, 1'b0);
        while (rx_st == 0) @(negedge clk);
        tx_en = 1'b0;
        wait_frames(base + 1);
        chk(dec_word[base] == 9'h05E, "R8 current frame completes", int'(dec_word[base]), 'h5E);
        chk(dec_stop[base] == 1'b1, "R8 stop sent", int'(dec_stop[base]), 1);
        wait_cycles(TICK_DIV * 15);
        chk(dec_cnt == base + 1, "R8 next held back", dec_cnt, base + 1);
        chk(buf_empty == 1'b0, "R8 next word kept", int'(buf_empty), 0);
        chk(tx_line == 1'b1, "R8 line high after stop", int'(tx_line), 1);
        tx_en = 1'b1;
        wait_frames(base + 2);
        chk(dec_word[base+1] == 9'h0A7, "R8 queued word sent", int'(dec_word[base+1]), 'hA7);
        wait_idle();
        chk(buf_empty && shift_empty, "R7 all empty at end", int'(shift_empty), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule